// File: doc/BRIEF.md
# DRAM Bank-Aware Command Sequencer

This block sits between a request queue and the command pins of a DDR-style DRAM device. Each request names a bank, a row and a column and says whether it is a read or a write. The sequencer records which row is open in every bank. From that record it decides, one cycle at a time, whether the request needs a PRECHARGE, an ACTIVATE, or can go straight out as a READ or WRITE. Each bank has its own busy timer. The timer is loaded with the programmed row-to-column delay after an ACTIVATE and with the programmed precharge delay after a PRECHARGE, so commands to different banks can be interleaved.

The queue holds a request stable until `req_ready` is seen high. That cycle is the cycle in which the column access is decided. All command pins are registered, so every command appears on the pins one clock after it is decided. A read-data-valid strobe follows each READ by the programmed CAS latency, and other commands may be issued while it is pending. An external refresh timer raises `ref_pending`. The sequencer then stops taking requests, closes every open bank, issues one REFRESH and pulses `ref_grant`.

Top module: `dram_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `dram_cke` is low and the pins carry no command (CS_n high). From the first clock edge after reset release, `dram_cke` is high.
- R2: A request to a bank with no open row puts ACTIVATE on the pins with `dram_addr` equal to the row. ACTIVATE is encoded as CS_n=0, ACT_n=0, RAS_n=CAS_n=WE_n=1. The access follows exactly tRCD cycles later if the request is held.
- R3: A request to a bank whose open row differs puts PRECHARGE (CS_n=0, ACT_n=1, RAS_n/CAS_n/WE_n = 0,1,0, address 0) on the pins for that bank. ACTIVATE with the new row follows exactly tRP cycles later, and the access follows tRCD cycles after that.
- R4: A request to the open row is issued directly. A read is READ (RAS_n/CAS_n/WE_n = 1,0,1) and a write is WRITE (1,0,0), with ACT_n=1 and the column on `dram_addr`. Consecutive hits go out one per cycle.
- R5: `req_ready` is high only in the cycle in which the READ or WRITE for the presented request is decided. That command is on the pins in the following cycle.
- R6: `rd_valid` is high for one cycle exactly CL cycles after each READ is on the pins. Reads may overlap their pending data windows.
- R7: Whenever CS_n is high, ACT_n, RAS_n, CAS_n and WE_n are all high. ACT_n is low only for ACTIVATE.
- R8: While `ref_pending` is high, `req_ready` stays low and no ACTIVATE is issued. Each cycle, the lowest-numbered bank that is open and no longer busy is precharged.
- R9: Once all banks are closed and no bank timer is running, a single REFRESH (RAS_n/CAS_n/WE_n = 0,0,1, bank 0, address 0) goes out with `ref_grant` high in the same cycle. There is no second REFRESH until `ref_pending` has been low.
- R10: Each bank keeps its own open row. Activity on one bank does not close or change the row that is open in another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented and held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Request accepted in this cycle |
| cfg_trcd | input | T_W | Activate-to-access delay in cycles (at least 1) |
| cfg_trp | input | T_W | Precharge-to-activate delay in cycles (at least 1) |
| cfg_cl | input | CL_W | CAS latency in cycles (1 to MAX_CL) |
| ref_pending | input | 1 | Refresh requested; stalls new work |
| ref_grant | output | 1 | High in the cycle REFRESH is on the pins |
| dram_cke | output | 1 | Clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_act_n | output | 1 | Activate marker, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_bank | output | BANK_W | Bank of the command on the pins |
| dram_addr | output | ADDR_W | Row or column of the command on the pins |
| rd_valid | output | 1 | Read data expected this cycle |

## Verification
The assertions take several things for granted about the inputs. The timing inputs are static between resets and are at least 1, the CAS latency is no larger than MAX_CL, and a presented request stays unchanged until it is accepted. Under those conditions, every ACTIVATE, PRECHARGE and access lands on a bank in the state that command needs. The stimulus changes the configuration only while reset is held, and it sweeps each of tRCD, tRP and CL over 1 to 3. It holds every request steady from the falling edge on which it is presented until the cycle `req_ready` is seen. It raises `ref_pending` only between requests, or with a request that it keeps waiting.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic act_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  // Active-low pin pattern for each command kind.
  function automatic pins_t encode_cmd(cmd_e c);
    pins_t p;
    p = pins_t'(5'b11111);
    case (c)
      CMD_ACT: begin p.cs_n = 1'b0; p.act_n = 1'b0; end
      CMD_RD:  begin p.cs_n = 1'b0; p.cas_n = 1'b0; end
      CMD_WR:  begin p.cs_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b0; end
      CMD_PRE: begin p.cs_n = 1'b0; p.ras_n = 1'b0; p.we_n = 1'b0; end
      CMD_REF: begin p.cs_n = 1'b0; p.ras_n = 1'b0; p.cas_n = 1'b0; end
      default: p = pins_t'(5'b11111);
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dram_bank_track.sv
module dram_bank_track #(
  parameter int ROW_W = 14,
  parameter int T_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_acc,
  input  logic [ROW_W-1:0] act_row,
  input  logic [T_W-1:0]   cfg_trcd,
  input  logic [T_W-1:0]   cfg_trp,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             ready
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [T_W-1:0]   wait_q;

  // A delay of N cycles keeps the bank busy for N-1 further cycles.
  function automatic logic [T_W-1:0] busy_load(input logic [T_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      wait_q <= '0;
    end else if (do_act) begin
      open_q <= 1'b1;
      row_q  <= act_row;
      wait_q <= busy_load(cfg_trcd);
    end else if (do_pre) begin
      open_q <= 1'b0;
      wait_q <= busy_load(cfg_trp);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign is_open  = open_q;
  assign open_row = row_q;
  assign ready    = (wait_q == '0);

  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) do_act |-> (!open_q && ready)); // R2
  AST_ACT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (do_act && cfg_trcd > 1) |=> !ready); // R2
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n) do_pre |-> (open_q && ready)); // R3
  AST_PRE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (do_pre && cfg_trp > 1) |=> !ready); // R3
  AST_ACC_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n) do_acc |-> (open_q && ready)); // R4

endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int MAX_CL = 8,
  parameter int CL_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [CL_W-1:0] cfg_cl,
  output logic            rd_valid
);

  logic [MAX_CL:0] pipe_q;

  // Stage 0 lines up with READ on the pins; stage CL is the data cycle.
  function automatic logic [CL_W-1:0] tap_of(input logic [CL_W-1:0] cl);
    if (cl == '0) return CL_W'(1);
    if (cl > CL_W'(MAX_CL)) return CL_W'(MAX_CL);
    return cl;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[MAX_CL-1:0], rd_issue};
  end

  assign rd_valid = pipe_q[tap_of(cfg_cl)];

  AST_CL1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_cl == CL_W'(1) && rd_valid) |-> $past(rd_issue, 2)); // R6

endmodule

// File: rtl/dram_cmd_pick.sv
module dram_cmd_pick
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 2
) (
  input  logic                            en,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W-1:0]               req_bank,
  input  logic [ROW_W-1:0]                req_row,
  input  logic                            ref_pending,
  input  logic                            ref_done,
  input  logic [NUM_BANKS-1:0]            bank_open,
  input  logic [NUM_BANKS-1:0]            bank_ready,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows,
  output cmd_e                            cmd,
  output logic [BANK_W-1:0]               cmd_bank,
  output logic                            take_req,
  output logic                            take_ref
);

  logic              any_open;
  logic              all_ready;
  logic              close_hit;
  logic [BANK_W-1:0] close_bank;

  assign any_open  = |bank_open;
  assign all_ready = &bank_ready;

  // Lowest-numbered bank that is open and free to be precharged.
  always_comb begin
    close_hit  = 1'b0;
    close_bank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bank_open[i] && bank_ready[i]) begin
        close_hit  = 1'b1;
        close_bank = BANK_W'(i);
      end
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    cmd_bank = '0;
    take_req = 1'b0;
    take_ref = 1'b0;
    if (en) begin
      if (ref_pending) begin
        if (close_hit) begin
          cmd      = CMD_PRE;
          cmd_bank = close_bank;
        end else if (!any_open && all_ready && !ref_done) begin
          cmd      = CMD_REF;
          take_ref = 1'b1;
        end
      end else if (req_valid && bank_ready[req_bank]) begin
        cmd_bank = req_bank;
        if (!bank_open[req_bank]) begin
          cmd = CMD_ACT;
        end else if (open_rows[req_bank] == req_row) begin
          cmd      = req_write ? CMD_WR : CMD_RD;
          take_req = 1'b1;
        end else begin
          cmd = CMD_PRE;
        end
      end
    end
  end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_W       = 4,
  parameter int MAX_CL    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int CL_W     = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  input  logic [T_W-1:0]    cfg_trcd,
  input  logic [T_W-1:0]    cfg_trp,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic              ref_pending,
  output logic              ref_grant,
  output logic              dram_cke,
  output logic              dram_cs_n,
  output logic              dram_act_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BANK_W-1:0] dram_bank,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              rd_valid
);

  // Named internal events
  cmd_e                            pick_cmd;
  logic [BANK_W-1:0]               pick_bank;
  logic                            pick_take;
  logic                            pick_ref;
  logic [NUM_BANKS-1:0]            trk_open;
  logic [NUM_BANKS-1:0]            trk_ready;
  logic [NUM_BANKS-1:0][ROW_W-1:0] trk_row;
  logic [NUM_BANKS-1:0]            evt_act;
  logic [NUM_BANKS-1:0]            evt_pre;
  logic [NUM_BANKS-1:0]            evt_acc;
  logic                            evt_rd;

  // Registered pin state
  logic              cke_q;
  logic              ref_done_q;
  logic              ref_grant_q;
  pins_t             pins_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] addr_for(input cmd_e c,
                                                 input logic [ROW_W-1:0] r,
                                                 input logic [COL_W-1:0] k);
    case (c)
      CMD_ACT:        return ADDR_W'(r);
      CMD_RD, CMD_WR: return ADDR_W'(k);
      default:        return '0;
    endcase
  endfunction

  dram_cmd_pick #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .BANK_W   (BANK_W)
  ) u_pick (
    .en         (cke_q),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .ref_pending(ref_pending),
    .ref_done   (ref_done_q),
    .bank_open  (trk_open),
    .bank_ready (trk_ready),
    .open_rows  (trk_row),
    .cmd        (pick_cmd),
    .cmd_bank   (pick_bank),
    .take_req   (pick_take),
    .take_ref   (pick_ref)
  );

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign evt_act[g] = (pick_cmd == CMD_ACT) && (pick_bank == BANK_W'(g));
      assign evt_pre[g] = (pick_cmd == CMD_PRE) && (pick_bank == BANK_W'(g));
      assign evt_acc[g] = ((pick_cmd == CMD_RD) || (pick_cmd == CMD_WR)) && (pick_bank == BANK_W'(g));

      dram_bank_track #(
        .ROW_W(ROW_W),
        .T_W  (T_W)
      ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_act  (evt_act[g]),
        .do_pre  (evt_pre[g]),
        .do_acc  (evt_acc[g]),
        .act_row (req_row),
        .cfg_trcd(cfg_trcd),
        .cfg_trp (cfg_trp),
        .is_open (trk_open[g]),
        .open_row(trk_row[g]),
        .ready   (trk_ready[g])
      );
    end
  endgenerate

  assign evt_rd = (pick_cmd == CMD_RD);

  dram_rd_pipe #(
    .MAX_CL(MAX_CL),
    .CL_W  (CL_W)
  ) u_rdp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_issue(evt_rd),
    .cfg_cl  (cfg_cl),
    .rd_valid(rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b0;
      ref_done_q  <= 1'b0;
      ref_grant_q <= 1'b0;
      pins_q      <= encode_cmd(CMD_NOP);
      bank_q      <= '0;
      addr_q      <= '0;
    end else begin
      cke_q       <= 1'b1;
      ref_done_q  <= ref_pending && (ref_done_q || pick_ref);
      ref_grant_q <= pick_ref;
      pins_q      <= encode_cmd(pick_cmd);
      bank_q      <= pick_bank;
      addr_q      <= addr_for(pick_cmd, req_row, req_col);
    end
  end

  assign req_ready  = pick_take;
  assign ref_grant  = ref_grant_q;
  assign dram_cke   = cke_q;
  assign dram_cs_n  = pins_q.cs_n;
  assign dram_act_n = pins_q.act_n;
  assign dram_ras_n = pins_q.ras_n;
  assign dram_cas_n = pins_q.cas_n;
  assign dram_we_n  = pins_q.we_n;
  assign dram_bank  = bank_q;
  assign dram_addr  = addr_q;

  AST_CKE_UP: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> dram_cke); // R1
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) dram_cs_n |-> (dram_act_n && dram_ras_n && dram_cas_n && dram_we_n)); // R7
  AST_ONE_BANK_EVT: assert property (@(posedge clk) disable iff (!rst_n) $countones({evt_act, evt_pre, evt_acc}) <= 1); // R7
  AST_NO_ACT_IN_REF: assert property (@(posedge clk) disable iff (!rst_n) ref_pending |-> (evt_act == '0)); // R8
  AST_NO_GRANT_IN_REF: assert property (@(posedge clk) disable iff (!rst_n) ref_pending |-> !req_ready); // R8
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) pick_ref |-> (trk_open == '0 && (&trk_ready))); // R9
  AST_REF_ONCE: assert property (@(posedge clk) disable iff (!rst_n) ref_grant |=> !ref_grant); // R9

endmodule

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;

  localparam int NB  = 4;
  localparam int RW  = 14;
  localparam int CW  = 10;
  localparam int TW  = 4;
  localparam int MCL = 8;
  localparam int BW  = 2;
  localparam int AW  = 14;
  localparam int CLW = 4;
  localparam int LOGN = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic          req_ready;
  logic [TW-1:0] cfg_trcd = 4'd1;
  logic [TW-1:0] cfg_trp = 4'd1;
  logic [CLW-1:0] cfg_cl = 4'd1;
  logic          ref_pending = 1'b0;
  logic          ref_grant;
  logic          dram_cke, dram_cs_n, dram_act_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [BW-1:0] dram_bank;
  logic [AW-1:0] dram_addr;
  logic          rd_valid;

  dram_cmd_seq u_dram_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_cl(cfg_cl),
    .ref_pending(ref_pending), .ref_grant(ref_grant),
    .dram_cke(dram_cke), .dram_cs_n(dram_cs_n), .dram_act_n(dram_act_n),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_bank(dram_bank), .dram_addr(dram_addr), .rd_valid(rd_valid)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  // Pin monitor: 1 ACT, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 9 illegal
  int lg_kind [LOGN];
  int lg_bank [LOGN];
  int lg_addr [LOGN];
  int lg_cyc  [LOGN];
  int lg_n = 0;
  int rv_cyc  [LOGN];
  int rv_n = 0;
  int rg_cyc  [LOGN];
  int rg_n = 0;
  int bad_idle = 0;

  function automatic int kind_of(logic a, logic r, logic c, logic w);
    if (!a) return ({r, c, w} == 3'b111) ? 1 : 9;
    case ({r, c, w})
      3'b101:  return 2;
      3'b100:  return 3;
      3'b010:  return 4;
      3'b001:  return 5;
      default: return 9;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_cs_n) begin
        if (lg_n < LOGN) begin
          lg_kind[lg_n] = kind_of(dram_act_n, dram_ras_n, dram_cas_n, dram_we_n);
          lg_bank[lg_n] = int'(dram_bank);
          lg_addr[lg_n] = int'(dram_addr);
          lg_cyc[lg_n]  = cyc;
        end
        lg_n = lg_n + 1;
      end else if (!(dram_act_n && dram_ras_n && dram_cas_n && dram_we_n)) begin
        bad_idle = bad_idle + 1;
      end
      if (rd_valid) begin
        if (rv_n < LOGN) rv_cyc[rv_n] = cyc;
        rv_n = rv_n + 1;
      end
      if (ref_grant) begin
        if (rg_n < LOGN) rg_cyc[rg_n] = cyc;
        rg_n = rg_n + 1;
      end
    end
  end

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d (tRCD=%0d tRP=%0d CL=%0d)",
               req, what, act, exp, cfg_trcd, cfg_trp, cfg_cl);
    end
  endtask

  task automatic expect_cmd(string req, int idx, int kind, int b, int addr, int c);
    chk_eq(req, "command kind", lg_kind[idx], kind);
    chk_eq(req, "command bank", lg_bank[idx], b);
    chk_eq(req, "command address", lg_addr[idx], addr);
    chk_eq(req, "command cycle", lg_cyc[idx], c);
  endtask

  // Present a request and hold it until accepted.
  task automatic issue(bit w, int b, int row, int col, output int s, output int a);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = BW'(b);
    req_row = RW'(row); req_col = CW'(col);
    s = cyc;
    #1;
    while (!req_ready && (cyc - s) < 100) begin
      @(negedge clk);
      #1;
    end
    a = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_config(int trcd, int trp, int cl);
    int s, a, lb, rb, gb, e;
    bit ready_seen;
    // Reset with the new configuration
    @(negedge clk);
    rst_n = 1'b0;
    cfg_trcd = TW'(trcd); cfg_trp = TW'(trp); cfg_cl = CLW'(cl);
    repeat (3) @(negedge clk);
    chk_eq("R1", "cke during reset", int'(dram_cke), 0);
    chk_eq("R1", "cs_n during reset", int'(dram_cs_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R1", "cke after reset", int'(dram_cke), 1);
    chk_eq("R1", "cs_n idle after reset", int'(dram_cs_n), 1);
    chk_eq("R1", "rd_valid idle after reset", int'(rd_valid), 0);

    // R2: closed bank read
    lb = lg_n; rb = rv_n;
    issue(1'b0, 0, 5, 3, s, a);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R2", "entries", lg_n - lb, 2);
    expect_cmd("R2", lb, 1, 0, 5, s + 1);
    expect_cmd("R2", lb + 1, 2, 0, 3, s + 1 + trcd);
    chk_eq("R5", "accept cycle", a, s + trcd);
    chk_eq("R6", "rd_valid count", rv_n - rb, 1);
    chk_eq("R6", "rd_valid cycle", rv_cyc[rb], s + 1 + trcd + cl);

    // R4: row hit read
    lb = lg_n; rb = rv_n;
    issue(1'b0, 0, 5, 7, s, a);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R4", "hit entries", lg_n - lb, 1);
    expect_cmd("R4", lb, 2, 0, 7, s + 1);
    chk_eq("R5", "hit accept cycle", a, s);
    chk_eq("R6", "hit rd_valid cycle", rv_cyc[rb], s + 1 + cl);

    // R2/R4: closed bank write on a second bank
    lb = lg_n; rb = rv_n;
    issue(1'b1, 1, 9, 2, s, a);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R2", "write entries", lg_n - lb, 2);
    expect_cmd("R2", lb, 1, 1, 9, s + 1);
    expect_cmd("R4", lb + 1, 3, 1, 2, s + 1 + trcd);
    chk_eq("R6", "no rd_valid for write", rv_n - rb, 0);

    // R10: bank 0 row still open after bank 1 activity
    lb = lg_n;
    issue(1'b0, 0, 5, 1, s, a);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R10", "interleave entries", lg_n - lb, 1);
    expect_cmd("R10", lb, 2, 0, 1, s + 1);

    // R3: row miss on bank 0
    lb = lg_n; rb = rv_n;
    issue(1'b0, 0, 6, 4, s, a);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R3", "miss entries", lg_n - lb, 3);
    expect_cmd("R3", lb, 4, 0, 0, s + 1);
    expect_cmd("R3", lb + 1, 1, 0, 6, s + 1 + trp);
    expect_cmd("R3", lb + 2, 2, 0, 4, s + 1 + trp + trcd);
    chk_eq("R5", "miss accept cycle", a, s + trp + trcd);
    chk_eq("R6", "miss rd_valid cycle", rv_cyc[rb], s + 1 + trp + trcd + cl);

    // R4: back-to-back writes to the open row of bank 1
    lb = lg_n;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd1; req_row = RW'(9);
    s = cyc;
    for (int i = 0; i < 4; i++) begin
      req_col = CW'(10 + i);
      #1;
      chk_eq("R4", "burst ready", int'(req_ready), 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R4", "burst entries", lg_n - lb, 4);
    for (int i = 0; i < 4; i++) expect_cmd("R4", lb + i, 3, 1, 10 + i, s + 1 + i);

    // R8/R9: refresh with banks 0 and 1 open and a request to bank 2 waiting
    lb = lg_n; rb = rv_n; gb = rg_n;
    @(negedge clk);
    ref_pending = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd2; req_row = RW'(3); req_col = CW'(5);
    s = cyc;
    ready_seen = 1'b0;
    #1;
    if (req_ready) ready_seen = 1'b1;
    for (int k = 0; k < trp + 6; k++) begin
      @(negedge clk);
      #1;
      if (req_ready) ready_seen = 1'b1;
    end
    chk_eq("R8", "req_ready during refresh", int'(ready_seen), 0);
    chk_eq("R8", "entries while pending", lg_n - lb, 3);
    expect_cmd("R8", lb, 4, 0, 0, s + 1);
    expect_cmd("R8", lb + 1, 4, 1, 0, s + 2);
    expect_cmd("R9", lb + 2, 5, 0, 0, s + 2 + trp);
    chk_eq("R9", "grant count", rg_n - gb, 1);
    chk_eq("R9", "grant cycle", rg_cyc[gb], s + 2 + trp);
    @(negedge clk);
    ref_pending = 1'b0;
    e = cyc;
    #1;
    while (!req_ready && (cyc - e) < 100) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R8", "entries after release", lg_n - lb, 5);
    expect_cmd("R8", lb + 3, 1, 2, 3, e + 1);
    expect_cmd("R2", lb + 4, 2, 2, 5, e + 1 + trcd);
    chk_eq("R6", "rd_valid after refresh", rv_cyc[rb], e + 1 + trcd + cl);
    chk_eq("R9", "single grant", rg_n - gb, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int t1 = 1; t1 <= 3; t1++)
      for (int t2 = 1; t2 <= 3; t2++)
        for (int t3 = 1; t3 <= 3; t3++)
          run_config(t1, t2, t3);
    chk_eq("R7", "idle cycles with a strobe low", bad_idle, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule